// File: doc/BRIEF.md
# Bias-Agreement Branch Direction Predictor

This block predicts the direction of conditional branches while limiting the harm done when unrelated branches share a counter. Each branch owns a bias bit, selected only by its address. A shared table of 2-bit saturating counters is selected by folding the branch address and XOR-ing it with a global outcome history. The counters do not record taken or not-taken. They record whether the branch tends to follow its own bias bit. Two branches that share a counter but both follow their own biases therefore push that counter the same way, even when their biases point in opposite directions.

A fetch stage presents an address on the prediction port. It receives a direction and the counter index that produced it, in the same cycle. When the branch resolves, the pipeline returns the address, the real outcome and that saved index on the update port. The update adjusts the counter, shifts the outcome into the history and, for a branch seen for the first time, learns its bias bit. A separate write port lets software or a profiler load a bias bit directly.

Top module: `agree_predictor`

## Requirements
- R1: After reset the history is zero, every counter holds the weak-agree code 2'b10 and every bias entry is invalid. Every prediction is then taken, and `pred_idx` equals the folded address.
- R2: `pred_idx` is the global history XOR the prediction address folded to IDX_W bits. The fold XORs consecutive IDX_W-bit slices of the address, and the last slice is zero-padded.
- R3: The bias entry is chosen by the address folded in the same way to BIAS_W bits, and by nothing else. The same branch reads the same bias bit under any history.
- R4: While the selected bias entry is invalid, `pred_taken` is 1.
- R5: With a valid bias entry, `pred_taken` equals the bias bit when the counter's upper bit is 1 (agree). It equals the inverted bias bit when the upper bit is 0 (disagree).
- R6: On an update, the counter at `upd_idx` moves up by one when the outcome matches the bias bit and down by one otherwise. It stays put at 2'b11 and at 2'b00.
- R7: An update whose bias entry is invalid stores the outcome as the bias bit and marks the entry valid. That update counts as an agreement for its counter.
- R8: Each update shifts the history left by one and puts the outcome in bit 0 (1 = taken). Without `upd_valid` the history holds.
- R9: A bias write stores the given bit and marks the entry valid. It replaces a learned value, and it wins over a first-time learn of the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_addr | input | ADDR_W | Address of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | IDX_W | Counter index used for this prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_idx | input | IDX_W | Counter index saved at prediction time |
| bias_wr_en | input | 1 | Load a bias bit directly |
| bias_wr_addr | input | ADDR_W | Branch address whose bias bit is loaded |
| bias_wr_val | input | 1 | Bias value to load |

## Verification
The bench runs the counters into both ends and then reverses them. A counter that wraps would turn a strong disagreement into a strong agreement, and the prediction would flip early. It loads the bias table through the write port, including in the same cycle as a first-time learn of the same entry. A design that let learning win, or kept a stale learned bit, would predict the wrong direction. It also probes the same branch under changing histories, and checks that idle cycles leave the history alone. A design that indexed the bias by the hashed index, or shifted the history without an update, would produce a wrong `pred_idx` or a wrong direction.

// File: rtl/agp_pkg.sv
package agp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_DISAGREE = 2'b00;
    localparam ctr_t CTR_WEAK_AGREE      = 2'b10;
    localparam ctr_t CTR_STRONG_AGREE    = 2'b11;

    // Saturating step: up on agreement, down otherwise.
    function automatic ctr_t ctr_step(ctr_t c, logic agree);
        if (agree) return (c == CTR_STRONG_AGREE) ? c : ctr_t'(c + 2'd1);
        else       return (c == CTR_STRONG_DISAGREE) ? c : ctr_t'(c - 2'd1);
    endfunction

    function automatic logic ctr_agrees(ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/agp_fold.sv
// XOR-folds a wide address down to OUT_W bits, zero-padding the last slice.
module agp_fold #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 6
) (
    input  logic [IN_W-1:0]  in_v,
    output logic [OUT_W-1:0] out_v
);
    localparam int NCH   = (IN_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W = NCH * OUT_W;

    generate
        if (NCH == 1) begin : g_pass
            assign out_v = OUT_W'(in_v);
        end else begin : g_fold
            logic [PAD_W-1:0] padded;
            assign padded = PAD_W'(in_v);
            always_comb begin
                out_v = '0;
                for (int i = 0; i < NCH; i++) out_v ^= padded[i*OUT_W +: OUT_W];
            end
        end
    endgenerate
endmodule

// File: rtl/agp_history.sv
module agp_history #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_o
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_en) s_d.hist = {s_q.hist[HIST_W-2:0], shift_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hist_o = s_q.hist;
endmodule

// File: rtl/agp_bias_table.sv
module agp_bias_table #(
    parameter int BIAS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BIAS_W-1:0] rd_a_idx,
    output logic              rd_a_bias,
    output logic              rd_a_vld,
    input  logic [BIAS_W-1:0] rd_b_idx,
    output logic              rd_b_bias,
    output logic              rd_b_vld,
    input  logic              learn_en,
    input  logic [BIAS_W-1:0] learn_idx,
    input  logic              learn_val,
    input  logic              wr_en,
    input  logic [BIAS_W-1:0] wr_idx,
    input  logic              wr_val
);
    localparam int DEPTH = 1 << BIAS_W;

    typedef struct packed {
        logic [DEPTH-1:0] bias;
        logic [DEPTH-1:0] vld;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // First resolution of an unknown branch fixes its bias.
        if (learn_en && !s_q.vld[learn_idx]) begin
            s_d.bias[learn_idx] = learn_val;
            s_d.vld[learn_idx]  = 1'b1;
        end
        // Direct load is applied last so it overrides learning.
        if (wr_en) begin
            s_d.bias[wr_idx] = wr_val;
            s_d.vld[wr_idx]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_a_bias = s_q.bias[rd_a_idx];
    assign rd_a_vld  = s_q.vld[rd_a_idx];
    assign rd_b_bias = s_q.bias[rd_b_idx];
    assign rd_b_vld  = s_q.vld[rd_b_idx];
endmodule

// File: rtl/agp_counter_table.sv
module agp_counter_table
    import agp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic [IDX_W-1:0] upd_idx,
    output ctr_t             upd_ctr,
    input  logic             upd_en,
    input  logic             upd_agree
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } state_t;

    localparam state_t RESET_STATE = '{ctr: {DEPTH{CTR_WEAK_AGREE}}};

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (upd_en) s_d.ctr[upd_idx] = ctr_step(s_q.ctr[upd_idx], upd_agree);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign rd_ctr  = s_q.ctr[rd_idx];
    assign upd_ctr = s_q.ctr[upd_idx];
endmodule

// File: rtl/agree_predictor.sv
module agree_predictor
    import agp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 6,
    parameter int BIAS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    output logic [IDX_W-1:0]  pred_idx,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              bias_wr_en,
    input  logic [ADDR_W-1:0] bias_wr_addr,
    input  logic              bias_wr_val
);
    localparam int HIST_W = IDX_W;

    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  pred_fold;
    logic [BIAS_W-1:0] pred_bidx, upd_bidx, wr_bidx;
    logic              pred_bias, pred_bias_vld;
    logic              upd_bias, upd_bias_vld;
    ctr_t              pred_ctr, upd_ctr;
    logic              upd_agree;

    agp_fold #(.IN_W(ADDR_W), .OUT_W(IDX_W))  u_fold_pi (.in_v(pred_addr),    .out_v(pred_fold));
    agp_fold #(.IN_W(ADDR_W), .OUT_W(BIAS_W)) u_fold_pb (.in_v(pred_addr),    .out_v(pred_bidx));
    agp_fold #(.IN_W(ADDR_W), .OUT_W(BIAS_W)) u_fold_ub (.in_v(upd_addr),     .out_v(upd_bidx));
    agp_fold #(.IN_W(ADDR_W), .OUT_W(BIAS_W)) u_fold_wb (.in_v(bias_wr_addr), .out_v(wr_bidx));

    assign pred_idx = hist_q ^ pred_fold;

    agp_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist_o    (hist_q)
    );

    agp_bias_table #(.BIAS_W(BIAS_W)) u_bias (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (pred_bidx),
        .rd_a_bias (pred_bias),
        .rd_a_vld  (pred_bias_vld),
        .rd_b_idx  (upd_bidx),
        .rd_b_bias (upd_bias),
        .rd_b_vld  (upd_bias_vld),
        .learn_en  (upd_valid),
        .learn_idx (upd_bidx),
        .learn_val (upd_taken),
        .wr_en     (bias_wr_en),
        .wr_idx    (wr_bidx),
        .wr_val    (bias_wr_val)
    );

    // An unknown bias is about to become the outcome itself: count as agree.
    assign upd_agree = !upd_bias_vld || (upd_taken == upd_bias);

    agp_counter_table #(.IDX_W(IDX_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (pred_idx),
        .rd_ctr    (pred_ctr),
        .upd_idx   (upd_idx),
        .upd_ctr   (upd_ctr),
        .upd_en    (upd_valid),
        .upd_agree (upd_agree)
    );

    always_comb begin
        if (!pred_bias_vld)          pred_taken = 1'b1;
        else if (ctr_agrees(pred_ctr)) pred_taken = pred_bias;
        else                         pred_taken = !pred_bias;
    end
endmodule

// File: rtl/agree_predictor_chk.sv
module agree_predictor_chk #(
    parameter int IDX_W  = 6,
    parameter int BIAS_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_taken,
    input logic              pred_bias_vld,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [IDX_W-1:0]  upd_idx,
    input logic [BIAS_W-1:0] upd_bidx,
    input logic              upd_bias_vld,
    input logic              upd_bias,
    input logic [1:0]        upd_ctr,
    input logic              bias_wr_en,
    input logic [BIAS_W-1:0] wr_bidx,
    input logic              bias_wr_val,
    input logic [IDX_W-1:0]  hist_q
);
    a_r4_unknown_bias_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_bias_vld |-> pred_taken);

    a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist_q == {$past(hist_q[IDX_W-2:0]), $past(upd_taken)});

    a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_q));

    a_r7_learn_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (upd_bidx != $past(upd_bidx)) || upd_bias_vld);

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bias_wr_en |=> (upd_bidx != $past(wr_bidx)) ||
                       (upd_bias_vld && upd_bias == $past(bias_wr_val)));

    a_r6_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ctr == 2'b11 && (!upd_bias_vld || upd_taken == upd_bias))
        |=> (upd_idx != $past(upd_idx)) || upd_ctr == 2'b11);

    a_r6_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_ctr == 2'b00 && upd_bias_vld && upd_taken != upd_bias)
        |=> (upd_idx != $past(upd_idx)) || upd_ctr == 2'b00);
endmodule

bind agree_predictor agree_predictor_chk #(.IDX_W(IDX_W), .BIAS_W(BIAS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_taken    (pred_taken),
    .pred_bias_vld (pred_bias_vld),
    .upd_valid     (upd_valid),
    .upd_taken     (upd_taken),
    .upd_idx       (upd_idx),
    .upd_bidx      (upd_bidx),
    .upd_bias_vld  (upd_bias_vld),
    .upd_bias      (upd_bias),
    .upd_ctr       (upd_ctr),
    .bias_wr_en    (bias_wr_en),
    .wr_bidx       (wr_bidx),
    .bias_wr_val   (bias_wr_val),
    .hist_q        (hist_q)
);

// File: tb/tb_agree_predictor.sv
module tb_agree_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int IW = 6;
    localparam int BW = 5;
    localparam int NVEC = 24;

    // Each vector: {outcome, address}
    localparam logic [NVEC-1:0][AW:0] VEC = '{
        {1'b1, 12'h040}, {1'b0, 12'h081}, {1'b1, 12'h040}, {1'b0, 12'h081},
        {1'b0, 12'h040}, {1'b1, 12'h3C7}, {1'b1, 12'h3C7}, {1'b0, 12'h040},
        {1'b1, 12'h081}, {1'b0, 12'h040}, {1'b1, 12'h0F2}, {1'b0, 12'h0F2},
        {1'b0, 12'h0F2}, {1'b1, 12'h040}, {1'b1, 12'h081}, {1'b1, 12'h081},
        {1'b0, 12'h3C7}, {1'b0, 12'h3C7}, {1'b1, 12'h0F2}, {1'b0, 12'h081},
        {1'b1, 12'h040}, {1'b1, 12'h040}, {1'b0, 12'h040}, {1'b1, 12'hA5D}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pred_addr = '0;
    logic          pred_taken;
    logic [IW-1:0] pred_idx;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic          upd_taken = 1'b0;
    logic [IW-1:0] upd_idx = '0;
    logic          bias_wr_en = 1'b0;
    logic [AW-1:0] bias_wr_addr = '0;
    logic          bias_wr_val = 1'b0;

    int checks = 0;
    int fails  = 0;

    // Reference state built from the requirements
    logic [1:0]    m_ctr  [1<<IW];
    logic          m_bias [1<<BW];
    logic          m_vld  [1<<BW];
    logic [IW-1:0] m_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    agree_predictor #(.ADDR_W(AW), .IDX_W(IW), .BIAS_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
        .pred_idx(pred_idx), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_taken(upd_taken), .upd_idx(upd_idx), .bias_wr_en(bias_wr_en),
        .bias_wr_addr(bias_wr_addr), .bias_wr_val(bias_wr_val)
    );

    function automatic logic [IW-1:0] fold_i(logic [AW-1:0] a);
        logic [IW-1:0] r = '0;
        for (int i = 0; i < AW; i++) r[i % IW] ^= a[i];
        return r;
    endfunction

    function automatic logic [BW-1:0] fold_b(logic [AW-1:0] a);
        logic [BW-1:0] r = '0;
        for (int i = 0; i < AW; i++) r[i % BW] ^= a[i];
        return r;
    endfunction

    function automatic logic model_pred(logic [AW-1:0] a);
        logic [BW-1:0] b = fold_b(a);
        logic [IW-1:0] c = m_hist ^ fold_i(a);
        if (!m_vld[b]) return 1'b1;
        return m_ctr[c][1] ? m_bias[b] : !m_bias[b];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1<<IW); i++) m_ctr[i] = 2'b10;
        for (int i = 0; i < (1<<BW); i++) begin m_bias[i] = 1'b0; m_vld[i] = 1'b0; end
        m_hist = '0;
    endtask

    task automatic model_update(logic uv, logic [AW-1:0] a, logic tk, logic [IW-1:0] ix,
                                logic we, logic [AW-1:0] wa, logic wv);
        logic [BW-1:0] b = fold_b(a);
        logic eff;
        if (uv) begin
            eff = m_vld[b] ? m_bias[b] : tk;
            if (tk == eff) m_ctr[ix] = (m_ctr[ix] == 2'b11) ? 2'b11 : m_ctr[ix] + 2'd1;
            else           m_ctr[ix] = (m_ctr[ix] == 2'b00) ? 2'b00 : m_ctr[ix] - 2'd1;
            if (!m_vld[b]) begin m_bias[b] = tk; m_vld[b] = 1'b1; end
            m_hist = {m_hist[IW-2:0], tk};
        end
        if (we) begin m_bias[fold_b(wa)] = wv; m_vld[fold_b(wa)] = 1'b1; end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: probe a prediction, optionally update and/or write a bias.
    task automatic step(logic [AW-1:0] a, logic uv, logic tk, logic force_ix,
                        logic [IW-1:0] fix, logic we, logic [AW-1:0] wa, logic wv,
                        string req);
        logic [IW-1:0] eidx;
        logic          ep;
        @(negedge clk);
        eidx = m_hist ^ fold_i(a);
        ep   = model_pred(a);
        pred_addr = a; upd_valid = uv; upd_addr = a; upd_taken = tk;
        upd_idx = force_ix ? fix : eidx;
        bias_wr_en = we; bias_wr_addr = wa; bias_wr_val = wv;
        #(CLK_PERIOD/4);
        check(req, 32'(pred_taken), 32'(ep));
        check("R2", 32'(pred_idx), 32'(eidx));
        @(posedge clk);
        model_update(uv, a, tk, upd_idx, we, wa, wv);
    endtask

    task automatic probe(logic [AW-1:0] a, string req);
        step(a, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0; bias_wr_en = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1: watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] p;
        do_reset();

        // R1 / R4: empty tables predict taken; pred_idx is the bare fold
        probe(12'h040, "R1");
        probe(12'h7FF, "R4");
        probe(12'h123, "R1");

        // Table walk: learning, agree/disagree, shared bias across histories
        for (int v = 0; v < NVEC; v++)
            step(VEC[v][AW-1:0], 1'b1, VEC[v][AW], 1'b0, '0, 1'b0, '0, 1'b0, "R5");

        // R3: same branch probed under the history left by the walk and after more shifts
        probe(12'h081, "R3");
        step(12'h3C7, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R3");
        probe(12'h081, "R3");

        // R8: idle cycles keep the history (pred_idx checked as R2 each probe)
        probe(12'h0F2, "R8");
        probe(12'h0F2, "R8");

        // R9: load every bias entry as taken through the write port
        for (int i = 0; i < (1<<BW); i++)
            step(12'h000, 1'b0, 1'b0, 1'b0, '0, 1'b1, AW'(i), 1'b1, "R9");

        // R6: drive counter 9 down past the bottom, then one step back up
        for (int k = 0; k < 5; k++)
            step(12'h155, 1'b1, 1'b0, 1'b1, 6'd9, 1'b0, '0, 1'b0, "R6");
        p = AW'(6'd9 ^ m_hist);
        probe(p, "R6");
        step(12'h155, 1'b1, 1'b1, 1'b1, 6'd9, 1'b0, '0, 1'b0, "R6");
        p = AW'(6'd9 ^ m_hist);
        probe(p, "R6");
        // Up past the top, then one disagreement keeps it agreeing
        for (int k = 0; k < 5; k++)
            step(12'h155, 1'b1, 1'b1, 1'b1, 6'd9, 1'b0, '0, 1'b0, "R6");
        step(12'h155, 1'b1, 1'b0, 1'b1, 6'd9, 1'b0, '0, 1'b0, "R6");
        p = AW'(6'd9 ^ m_hist);
        probe(p, "R6");

        // R9: overwrite a loaded bias to not-taken; prediction follows
        step(12'h0A3, 1'b0, 1'b0, 1'b0, '0, 1'b1, 12'h0A3, 1'b0, "R9");
        probe(12'h0A3, "R9");

        // R7 / R9: fresh tables; write and first learn hit the same entry together
        do_reset();
        step(12'h0A3, 1'b1, 1'b1, 1'b0, '0, 1'b1, 12'h0A3, 1'b0, "R9");
        probe(12'h0A3, "R9");
        step(12'h2B4, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R7");
        probe(12'h2B4, "R7");
        step(12'h2B4, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R7");
        probe(12'h2B4, "R7");

        // R1: mid-run reset clears learned state
        step(12'h311, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R7");
        do_reset();
        probe(12'h311, "R1");
        probe(12'h2B4, "R1");

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule